// File: doc/BRIEF.md
# Codec Control Slot Command Engine

This block carries control-register traffic between software and an audio codec. Software sees two transmit slot registers and two receive slot registers. It first loads the data slot, then writes the command slot. That command write starts one codec register transaction. The engine picks a read/write flag and a 7-bit register address out of the command word. On a write, it sends the address and the 16-bit data field to the codec register port. On a read, it fetches a 16-bit value from the codec. It then posts the value into the two receive slots in the same layout a returned frame would use.

The engine also keeps a flag register. It shows whether each transmit slot, and the pair, is still untouched since reset. It shows whether a read response is pending and whether fresh response data is waiting. The codec port is a request/acknowledge handshake, so the engine works with any codec latency.

Top module: `codec_slot_engine`

## Requirements
- R1: After reset the flag register reads 0x07 and every other register reads zero. Flag bits are: bit0 command-slot empty, bit1 data-slot empty, bit2 pair empty, bit3 command receive busy, bit4 data receive busy, bit5 command receive valid, bit6 data receive valid. At the same time, `cmd_req_o` is low.
- R2: A write with `sel_i`=1 stores the 20-bit word in the data slot. It clears bit1 and bit2 and leaves bit0 alone.
- R3: When no transaction is outstanding, a write with `sel_i`=0 stores the command word and clears bit0 and bit2. It also raises `cmd_req_o` on the next cycle. Bit 19 of the command word selects the operation (1 read, 0 write), and bits 18:12 give `cmd_addr_o`.
- R4: For a write command, `cmd_we_o` is high and `cmd_wdata_o` carries bits 19:4 of the data slot. `cmd_req_o` stays high until a cycle with `cmd_ack_i` high and drops on the cycle after it.
- R5: For a read command, `cmd_we_o` is low. Bits 3 and 4 are set from the cycle after the command write until the cycle after the acknowledge.
- R6: A read completes on the cycle after its acknowledge. The command receive slot (`sel_i`=2) then holds the command word with bit 19 cleared. The data receive slot (`sel_i`=3) holds `cmd_rdata_i` shifted left by 4. Bits 3 and 4 clear and bits 5 and 6 set.
- R7: A register read puts the selected value on `rdata_o` the cycle after `rd_en_i`. Reading `sel_i`=2 clears bit5, and reading `sel_i`=3 clears bit6. A completion in the same cycle keeps the flag set.
- R8: A command write made while a transaction is outstanding is ignored. The command slot, the flags and the codec request all stay as they were.
- R9: An acknowledge with no outstanding request changes no flag and no receive slot.
- R10: `sel_i` 4 reads the flag register. Selectors 5 to 7 read zero, and writes to selectors 2 to 7 have no effect.
- R11: The address, direction and data presented to the codec stay fixed for the whole transaction, even if the data slot is rewritten meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| sel_i | input | 3 | Register selector |
| wdata_i | input | 20 | Register write data |
| rdata_o | output | 20 | Register read data, registered |
| cmd_req_o | output | 1 | Codec access request |
| cmd_we_o | output | 1 | Codec access is a write |
| cmd_addr_o | output | 7 | Codec register address |
| cmd_wdata_o | output | 16 | Codec write data |
| cmd_ack_i | input | 1 | Codec access acknowledge |
| cmd_rdata_i | input | 16 | Codec read data, valid with acknowledge |

## Verification
The request and its fields appear one cycle after the command write. The receive slots and flags change one cycle after the acknowledge. Register read data appears one cycle after the read strobe. The bench drives inputs on falling edges and samples on the next falling edge, so every result is sampled one full edge after its cause.

A bench-side codec model acknowledges after a latency that varies per address. The bench polls the request until it drops, and only then inspects the receive slots. Because of this, no check depends on a fixed codec delay.

// File: rtl/codec_slot_pkg.sv
package codec_slot_pkg;
  localparam int SLOT_W   = 20;
  localparam int ADDR_W   = 7;
  localparam int DATA_W   = 16;
  localparam int RW_BIT   = 19;
  localparam int ADDR_LSB = 12;
  localparam int DATA_LSB = 4;
  localparam int SEL_W    = 3;
  localparam int N_SLOT   = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_CMD_TX  = 3'd0,
    SEL_DATA_TX = 3'd1,
    SEL_CMD_RX  = 3'd2,
    SEL_DATA_RX = 3'd3,
    SEL_FLAGS   = 3'd4
  } slot_sel_e;

  // bit0 is the last member
  typedef struct packed {
    logic data_rx_valid;
    logic cmd_rx_valid;
    logic data_rx_busy;
    logic cmd_rx_busy;
    logic pair_tx_empty;
    logic data_tx_empty;
    logic cmd_tx_empty;
  } slot_flags_t;

  localparam int FLAGS_W = $bits(slot_flags_t);
endpackage

// File: rtl/tx_slots.sv
module tx_slots #(
  parameter int SLOT_W = 20,
  parameter int N_SLOT = 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [N_SLOT-1:0]              wr_i,
  input  logic [SLOT_W-1:0]              wdata_i,
  output logic [N_SLOT-1:0][SLOT_W-1:0]  slot_o,
  output logic [N_SLOT-1:0]              empty_o,
  output logic                           pair_empty_o
);
  for (genvar i = 0; i < N_SLOT; i++) begin : g_slot
    logic [SLOT_W-1:0] q;
    logic              empty_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q       <= '0;
        empty_q <= 1'b1;
      end else if (wr_i[i]) begin
        q       <= wdata_i;
        empty_q <= 1'b0;
      end
    end
    assign slot_o[i]  = q;
    assign empty_o[i] = empty_q;
  end

  logic pair_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pair_q <= 1'b1;
    else if (|wr_i)  pair_q <= 1'b0;
  end
  assign pair_empty_o = pair_q;
endmodule

// File: rtl/cmd_seq.sv
module cmd_seq #(
  parameter int SLOT_W   = 20,
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 16,
  parameter int RW_BIT   = 19,
  parameter int ADDR_LSB = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [SLOT_W-1:0] cmd_word_i,
  input  logic [DATA_W-1:0] data_word_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [SLOT_W-1:0] echo_o,
  output logic              busy_o,
  output logic              rd_issue_o,
  output logic              rd_done_o
);
  typedef enum logic {ST_IDLE, ST_WAIT} seq_state_e;
  localparam logic [SLOT_W-1:0] RW_MASK = SLOT_W'(1) << RW_BIT;

  seq_state_e        state_q;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [SLOT_W-1:0] echo_q;
  logic              accept;

  assign accept = start_i && (state_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      echo_q  <= '0;
    end else if (accept) begin
      state_q <= ST_WAIT;
      we_q    <= !cmd_word_i[RW_BIT];
      addr_q  <= cmd_word_i[ADDR_LSB +: ADDR_W];
      wdata_q <= data_word_i;
      echo_q  <= cmd_word_i & ~RW_MASK;
    end else if (state_q == ST_WAIT && ack_i) begin
      state_q <= ST_IDLE;
    end
  end

  assign req_o      = (state_q == ST_WAIT);
  assign busy_o     = req_o;
  assign we_o       = we_q;
  assign addr_o     = addr_q;
  assign wdata_o    = wdata_q;
  assign echo_o     = echo_q;
  assign rd_issue_o = accept && cmd_word_i[RW_BIT];
  assign rd_done_o  = req_o && ack_i && !we_q;
endmodule

// File: rtl/rx_slots.sv
module rx_slots #(
  parameter int SLOT_W   = 20,
  parameter int DATA_W   = 16,
  parameter int DATA_LSB = 4,
  parameter int N_SLOT   = 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           issue_i,
  input  logic                           load_i,
  input  logic [SLOT_W-1:0]              echo_i,
  input  logic [DATA_W-1:0]              rdata_i,
  input  logic [N_SLOT-1:0]              clr_i,
  output logic [N_SLOT-1:0][SLOT_W-1:0]  slot_o,
  output logic [N_SLOT-1:0]              busy_o,
  output logic [N_SLOT-1:0]              valid_o
);
  for (genvar i = 0; i < N_SLOT; i++) begin : g_slot
    logic [SLOT_W-1:0] nxt;
    logic [SLOT_W-1:0] q;
    logic              busy_q;
    logic              valid_q;

    if (i == 0) begin : g_cmd
      assign nxt = echo_i;
    end else begin : g_data
      assign nxt = SLOT_W'(rdata_i) << DATA_LSB;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        q       <= '0;
        busy_q  <= 1'b0;
        valid_q <= 1'b0;
      end else begin
        if (load_i) q <= nxt;
        if (issue_i)     busy_q <= 1'b1;
        else if (load_i) busy_q <= 1'b0;
        // completion wins over a clearing read
        if (load_i)        valid_q <= 1'b1;
        else if (clr_i[i]) valid_q <= 1'b0;
      end
    end
    assign slot_o[i]  = q;
    assign busy_o[i]  = busy_q;
    assign valid_o[i] = valid_q;
  end
endmodule

// File: rtl/codec_slot_engine.sv
module codec_slot_engine
  import codec_slot_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [SLOT_W-1:0] wdata_i,
  output logic [SLOT_W-1:0] rdata_o,
  output logic              cmd_req_o,
  output logic              cmd_we_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [DATA_W-1:0] cmd_wdata_o,
  input  logic              cmd_ack_i,
  input  logic [DATA_W-1:0] cmd_rdata_i
);
  logic                          wr_cmd, wr_dat, start, busy;
  logic                          rd_issue, rd_done;
  logic [N_SLOT-1:0]             rx_clr;
  logic [N_SLOT-1:0][SLOT_W-1:0] tx_slot, rx_slot;
  logic [N_SLOT-1:0]             tx_empty, rx_busy, rx_valid;
  logic                          pair_empty;
  logic [SLOT_W-1:0]             echo;
  slot_flags_t                   flags;
  logic [SLOT_W-1:0]             rd_mux, rdata_q;

  assign wr_cmd    = wr_en_i && (sel_i == SEL_CMD_TX);
  assign wr_dat    = wr_en_i && (sel_i == SEL_DATA_TX);
  assign start     = wr_cmd && !busy;
  assign rx_clr[0] = rd_en_i && (sel_i == SEL_CMD_RX);
  assign rx_clr[1] = rd_en_i && (sel_i == SEL_DATA_RX);

  tx_slots #(.SLOT_W(SLOT_W), .N_SLOT(N_SLOT)) u_tx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         ({wr_dat, start}),
    .wdata_i      (wdata_i),
    .slot_o       (tx_slot),
    .empty_o      (tx_empty),
    .pair_empty_o (pair_empty)
  );

  cmd_seq #(
    .SLOT_W(SLOT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .RW_BIT(RW_BIT), .ADDR_LSB(ADDR_LSB)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .cmd_word_i  (wdata_i),
    .data_word_i (tx_slot[1][DATA_LSB +: DATA_W]),
    .ack_i       (cmd_ack_i),
    .req_o       (cmd_req_o),
    .we_o        (cmd_we_o),
    .addr_o      (cmd_addr_o),
    .wdata_o     (cmd_wdata_o),
    .echo_o      (echo),
    .busy_o      (busy),
    .rd_issue_o  (rd_issue),
    .rd_done_o   (rd_done)
  );

  rx_slots #(
    .SLOT_W(SLOT_W), .DATA_W(DATA_W), .DATA_LSB(DATA_LSB), .N_SLOT(N_SLOT)
  ) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .issue_i (rd_issue),
    .load_i  (rd_done),
    .echo_i  (echo),
    .rdata_i (cmd_rdata_i),
    .clr_i   (rx_clr),
    .slot_o  (rx_slot),
    .busy_o  (rx_busy),
    .valid_o (rx_valid)
  );

  always_comb begin
    flags.cmd_tx_empty  = tx_empty[0];
    flags.data_tx_empty = tx_empty[1];
    flags.pair_tx_empty = pair_empty;
    flags.cmd_rx_busy   = rx_busy[0];
    flags.data_rx_busy  = rx_busy[1];
    flags.cmd_rx_valid  = rx_valid[0];
    flags.data_rx_valid = rx_valid[1];
  end

  always_comb begin
    rd_mux = '0;
    case (sel_i)
      SEL_CMD_TX:  rd_mux = tx_slot[0];
      SEL_DATA_TX: rd_mux = tx_slot[1];
      SEL_CMD_RX:  rd_mux = rx_slot[0];
      SEL_DATA_RX: rd_mux = rx_slot[1];
      SEL_FLAGS:   rd_mux[FLAGS_W-1:0] = flags;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end
  assign rdata_o = rdata_q;
endmodule

// File: rtl/codec_slot_engine_chk.sv
module codec_slot_engine_chk
  import codec_slot_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic              start_rw_i,
  input logic [ADDR_W-1:0] start_addr_i,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              ack_i,
  input logic [DATA_W-1:0] rdata_i,
  input slot_flags_t       flags_i,
  input logic [SLOT_W-1:0] cmd_rx_i,
  input logic [SLOT_W-1:0] data_rx_i
);
  AST_START_DECODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_i) |-> (addr_i == $past(start_addr_i)) && (we_i == !$past(start_rw_i))); // R3

  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !ack_i |=> req_i); // R4

  AST_REQ_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && ack_i |=> !req_i); // R4

  AST_BUSY_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i |-> flags_i.cmd_rx_busy && flags_i.data_rx_busy); // R5

  AST_READ_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && ack_i |=> !flags_i.cmd_rx_busy && !flags_i.data_rx_busy
      && flags_i.cmd_rx_valid && flags_i.data_rx_valid
      && (data_rx_i == (SLOT_W'($past(rdata_i)) << DATA_LSB))); // R6

  AST_ECHO_RW_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && ack_i |=> !cmd_rx_i[RW_BIT]); // R6

  AST_FIELDS_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !ack_i |=> $stable(addr_i) && $stable(wdata_i) && $stable(we_i)); // R11

  AST_IDLE_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i && ack_i && !wr_en_i && !rd_en_i |=> $stable(flags_i) && $stable(cmd_rx_i)
      && $stable(data_rx_i)); // R9
endmodule

bind codec_slot_engine codec_slot_engine_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .rd_en_i      (rd_en_i),
  .start_rw_i   (wdata_i[RW_BIT]),
  .start_addr_i (wdata_i[ADDR_LSB +: ADDR_W]),
  .req_i        (cmd_req_o),
  .we_i         (cmd_we_o),
  .addr_i       (cmd_addr_o),
  .wdata_i      (cmd_wdata_o),
  .ack_i        (cmd_ack_i),
  .rdata_i      (cmd_rdata_i),
  .flags_i      (flags),
  .cmd_rx_i     (rx_slot[0]),
  .data_rx_i    (rx_slot[1])
);

// File: tb/codec_slot_engine_test.sv
`timescale 1ns/1ps
module codec_slot_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  sel = '0;
  logic [19:0] wdata = '0;
  logic [19:0] rdata;
  logic        req, we;
  logic [6:0]  addr;
  logic [15:0] cwdata;
  logic        ack;
  logic [15:0] crdata;

  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  codec_slot_engine uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .sel_i(sel),
    .wdata_i(wdata), .rdata_o(rdata), .cmd_req_o(req), .cmd_we_o(we),
    .cmd_addr_o(addr), .cmd_wdata_o(cwdata), .cmd_ack_i(ack), .cmd_rdata_i(crdata)
  );

  // codec register file model
  logic [15:0] mem [128];
  int  lat = 0, cnt = 0;
  bit  ack_en = 1, force_ack = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack <= 1'b0; crdata <= '0; cnt <= 0;
    end else if (force_ack) begin
      ack <= 1'b1; crdata <= 16'hBEEF;
    end else if (ack) begin
      ack <= 1'b0;
    end else if (req && ack_en) begin
      if (cnt >= lat) begin
        ack <= 1'b1; cnt <= 0;
        if (we) mem[addr] <= cwdata;
        else    crdata <= mem[addr];
      end else cnt <= cnt + 1;
    end
  end

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", rq, act, exp);
    end
  endtask

  task automatic bus_write(logic [2:0] s, logic [19:0] d);
    @(negedge clk); wr_en = 1'b1; sel = s; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_read(logic [2:0] s, output logic [19:0] v);
    @(negedge clk); rd_en = 1'b1; sel = s;
    @(negedge clk); rd_en = 1'b0; v = rdata;
  endtask

  task automatic wait_done();
    for (int k = 0; k < 100 && req; k++) @(negedge clk);
  endtask

  function automatic logic [15:0] dval(int a);
    return 16'((a * 16'h0151) ^ 16'h3C3C);
  endfunction

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic [19:0] v, cmd, prev_d, prev_f;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 req", req, 0);
    bus_read(3'd4, v); chk("R1 flags", v, 20'h07);
    bus_read(3'd2, v); chk("R1 cmd rx", v, 0);
    bus_read(3'd3, v); chk("R1 data rx", v, 0);
    bus_read(3'd0, v); chk("R1 cmd tx", v, 0);

    // R10 unused selectors
    for (int s = 5; s < 8; s++) begin
      bus_read(3'(s), v); chk("R10 unused read", v, 0);
    end
    bus_write(3'd6, 20'hFFFFF);
    bus_write(3'd2, 20'h12345);
    bus_read(3'd4, v); chk("R10 write ignored flags", v, 20'h07);
    bus_read(3'd2, v); chk("R10 write ignored rx", v, 0);

    // R2 data slot
    bus_write(3'd1, 20'h12345);
    bus_read(3'd1, v); chk("R2 data slot", v, 20'h12345);
    bus_read(3'd4, v); chk("R2 flags", v, 20'h01);

    // R3/R4 write sweep over every address
    for (int a = 0; a < 128; a++) begin
      lat = a % 4;
      bus_write(3'd1, {dval(a), 4'(a)});
      cmd = {1'b0, 7'(a), 12'(a * 3)};
      bus_write(3'd0, cmd);
      chk("R3 req", req, 1);
      chk("R3 addr", addr, a);
      chk("R4 we", we, 1);
      chk("R4 wdata", cwdata, dval(a));
      if (a == 0) begin
        bus_read(3'd4, v); chk("R3 flags", v, 20'h00);
      end
      wait_done();
      chk("R4 req drop", req, 0);
    end

    // R5/R6/R7 read sweep
    for (int a = 0; a < 128; a++) begin
      lat = (a == 0) ? 6 : a % 3;
      cmd = {1'b1, 7'(a), 12'(a * 5 + 1)};
      bus_write(3'd0, cmd);
      chk("R5 we", we, 0);
      chk("R3 read addr", addr, a);
      if (a == 0) begin
        bus_read(3'd4, v); chk("R5 busy", v, 20'h18);
      end
      wait_done();
      bus_read(3'd4, v); chk("R6 flags", v, 20'h60);
      bus_read(3'd2, v); chk("R6 cmd echo", v, cmd & 20'h7FFFF);
      bus_read(3'd4, v); chk("R7 cmd valid clr", v, 20'h40);
      bus_read(3'd3, v); chk("R6 data rx", v, {dval(a), 4'h0});
      bus_read(3'd4, v); chk("R7 data valid clr", v, 20'h00);
    end

    // R8/R11 writes during an outstanding transaction
    ack_en = 0; lat = 0;
    bus_write(3'd1, 20'h0AAAA0);
    cmd = {1'b0, 7'h11, 12'h321};
    bus_write(3'd0, cmd);
    bus_write(3'd1, 20'h0FFFF0);
    chk("R11 wdata held", cwdata, 16'hAAAA);
    bus_write(3'd0, {1'b1, 7'h22, 12'h0});
    chk("R8 addr held", addr, 7'h11);
    chk("R8 we held", we, 1);
    bus_read(3'd0, v); chk("R8 cmd slot kept", v, cmd);
    bus_read(3'd4, v); chk("R8 no busy", v, 20'h00);
    chk("R8 req", req, 1);
    ack_en = 1;
    wait_done();
    chk("R4 req drop late", req, 0);
    bus_write(3'd0, {1'b1, 7'h11, 12'h0});
    wait_done();
    bus_read(3'd3, v); chk("R4 written value", v, 20'hAAAA0);

    // R9 acknowledge while idle
    bus_read(3'd3, prev_d);
    bus_read(3'd4, prev_f);
    @(negedge clk); force_ack = 1;
    @(negedge clk); force_ack = 0;
    repeat (2) @(negedge clk);
    bus_read(3'd4, v); chk("R9 flags", v, prev_f);
    bus_read(3'd3, v); chk("R9 data rx", v, prev_d);
    chk("R9 req", req, 0);

    done = 1;
    finish_run();
  end
endmodule